// File: doc/BRIEF.md
# Programmable-Duty Serial Clock Generator

This block derives a serial-interface clock from the system clock. Software-visible fields are not part of it; three counts arrive as plain inputs: a period count that makes each output period last one cycle longer than its value, and two threshold counts whose signed difference fixes how long the clock stays high or low. Only the magnitude and sign of that difference matter, not where the two thresholds sit. Every period opens with its high phase and closes with its low phase.

Alongside the clock the block emits single-cycle strobes in the first system cycle of each high phase and of each low phase, so neighbouring shift logic can launch and capture data without detecting edges itself. A bypass input hands the system clock straight to the output. A configuration whose thresholds are equal, or exceed the period count, parks the clock low and raises an error flag. New counts take effect only at a period boundary, so a running period is never cut short or stretched.

Top module: `sclk_duty_gen`

## Requirements
- R1: With enable high, bypass low and a legal configuration, every output period lasts exactly N+1 system cycles, where N is the value on `per_cnt`.
- R2: When `thr_a` is greater than `thr_b`, the clock is high for `thr_a`-`thr_b` cycles of each period and low for the remaining cycles.
- R3: When `thr_a` is less than `thr_b`, the clock is low for `thr_b`-`thr_a` cycles of each period and high for the remaining cycles.
- R4: Each period starts with its high phase and ends with its low phase, whichever threshold is larger.
- R5: Only the threshold difference matters: with N = 9, the pairs (9,3) and (6,0) give the same 6-high, 4-low waveform.
- R6: While `bypass` is 1, `sclk_o` equals `clk`, both strobes stay 0 and `cfg_err` stays 0, whatever the counts are.
- R7: If the thresholds are equal or either exceeds N, from the cycle after that configuration is taken `cfg_err` is 1, `sclk_o` stays 0 and no strobe pulses.
- R8: Count and threshold inputs are sampled only at the system edge that starts a new period (or while idle); a change in mid-period leaves the running period unchanged and applies from the next.
- R9: While `en` is 0 the clock is 0 and the cycle counter is held at zero; in the first cycle after `en` is seen high, `sclk_o` is 1 and `rise_stb` pulses.
- R10: `rise_stb` is 1 in exactly the first cycle of each high phase and `fall_stb` in exactly the first cycle of each low phase; the two are never 1 together.
- R11: While `rst_n` is 0, `sclk_o`, `rise_stb`, `fall_stb` and `cfg_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low idles the clock low |
| bypass | input | 1 | 1 passes the system clock straight to the output |
| per_cnt | input | CNT_W | Period count N; period is N+1 cycles |
| thr_a | input | CNT_W | First threshold (larger gives a longer high phase) |
| thr_b | input | CNT_W | Second threshold (larger gives a longer low phase) |
| sclk_o | output | 1 | Generated serial clock |
| rise_stb | output | 1 | Pulse in the first cycle of each high phase |
| fall_stb | output | 1 | Pulse in the first cycle of each low phase |
| cfg_err | output | 1 | Captured configuration is illegal |

## Verification
The bench measures high and low run lengths for directed and random legal counts in both threshold orders, so a design that took the unsigned difference, started with the low phase, or was off by one on the period would miscount a run. It changes the counts in the middle of a period and expects the running period to finish unchanged, which catches capture outside the boundary. It drives equal thresholds and a threshold above N, where a design lacking the guard would produce a zero-length or overlong phase, and it toggles enable to see the first period open high with a rise strobe. In bypass it samples the output on both clock levels while illegal counts are present, which exposes a design that still decodes the counts.

// File: rtl/sdg_pkg.sv
package sdg_pkg;

   localparam int unsigned SDG_MAX_W = 16;

   typedef enum logic [1:0] {
      CFG_OK    = 2'd0,
      CFG_EQUAL = 2'd1,
      CFG_RANGE = 2'd2
   } cfg_stat_e;

endpackage

// File: rtl/sdg_cfg_capture.sv
module sdg_cfg_capture
   import sdg_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] n_in,
   input  logic [CNT_W-1:0] a_in,
   input  logic [CNT_W-1:0] b_in,
   output logic [CNT_W-1:0] n_q,
   output logic [CNT_W-1:0] hi_len_q,
   output logic             err_q
);

   cfg_stat_e        stat;
   logic [CNT_W-1:0] hi_len_d;

   always_comb begin
      if (a_in > n_in || b_in > n_in) stat = CFG_RANGE;
      else if (a_in == b_in)          stat = CFG_EQUAL;
      else                            stat = CFG_OK;
   end

   // high phase length: the difference when a>b, otherwise the remainder
   always_comb begin
      if (a_in > b_in) hi_len_d = a_in - b_in;
      else             hi_len_d = n_in + CNT_W'(1) - (b_in - a_in);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_q      <= '0;
         hi_len_q <= '0;
         err_q    <= 1'b0;
      end else if (load) begin
         n_q      <= n_in;
         hi_len_q <= hi_len_d;
         err_q    <= (stat != CFG_OK);
      end
   end

endmodule

// File: rtl/sdg_phase_cnt.sv
module sdg_phase_cnt #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] n_cur,
   output logic [CNT_W-1:0] cnt_q,
   output logic             active_q,
   output logic             load
);

   logic at_end;

   assign at_end = (cnt_q == n_cur);
   assign load   = !active_q || at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (!en) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else begin
         active_q <= 1'b1;
         if (active_q) cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/sdg_edge_out.sv
module sdg_edge_out #(
   parameter int unsigned CNT_W     = 8,
   parameter bit          BYPASS_EN = 1'b1
) (
   input  logic             clk,
   input  logic             bypass,
   input  logic             active,
   input  logic             err,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] hi_len,
   output logic             sclk_o,
   output logic             rise_stb,
   output logic             fall_stb,
   output logic             cfg_err
);

   logic run;
   logic div_clk;
   logic div_rise;
   logic div_fall;

   assign run      = active && !err;
   assign div_clk  = run && (cnt < hi_len);
   assign div_rise = run && (cnt == '0);
   assign div_fall = run && (cnt == hi_len);

   generate
      if (BYPASS_EN) begin : g_bypass
         assign sclk_o   = bypass ? clk : div_clk;
         assign rise_stb = div_rise && !bypass;
         assign fall_stb = div_fall && !bypass;
         assign cfg_err  = err && !bypass;
      end else begin : g_no_bypass
         logic unused_bypass;
         assign unused_bypass = bypass ^ clk;
         assign sclk_o   = div_clk;
         assign rise_stb = div_rise;
         assign fall_stb = div_fall;
         assign cfg_err  = err;
      end
   endgenerate

endmodule

// File: rtl/sclk_duty_gen.sv
module sclk_duty_gen
   import sdg_pkg::*;
#(
   parameter int unsigned CNT_W     = 8,
   parameter bit          BYPASS_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             bypass,
   input  logic [CNT_W-1:0] per_cnt,
   input  logic [CNT_W-1:0] thr_a,
   input  logic [CNT_W-1:0] thr_b,
   output logic             sclk_o,
   output logic             rise_stb,
   output logic             fall_stb,
   output logic             cfg_err
);

   generate
      if (CNT_W < 2 || CNT_W > SDG_MAX_W) begin : g_bad_width
         $error("sclk_duty_gen: CNT_W must lie in 2..16");
      end
   endgenerate

   logic [CNT_W-1:0] n_cur;
   logic [CNT_W-1:0] hi_len;
   logic [CNT_W-1:0] cnt_q;
   logic             err_q;
   logic             active_q;
   logic             load;

   sdg_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .n_cur    (n_cur),
      .cnt_q    (cnt_q),
      .active_q (active_q),
      .load     (load)
   );

   sdg_cfg_capture #(.CNT_W(CNT_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .n_in     (per_cnt),
      .a_in     (thr_a),
      .b_in     (thr_b),
      .n_q      (n_cur),
      .hi_len_q (hi_len),
      .err_q    (err_q)
   );

   sdg_edge_out #(.CNT_W(CNT_W), .BYPASS_EN(BYPASS_EN)) u_out (
      .clk      (clk),
      .bypass   (bypass),
      .active   (active_q),
      .err      (err_q),
      .cnt      (cnt_q),
      .hi_len   (hi_len),
      .sclk_o   (sclk_o),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb),
      .cfg_err  (cfg_err)
   );

endmodule

// File: rtl/sdg_checker.sv
module sdg_checker #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             bypass,
   input logic             sclk_o,
   input logic             rise_stb,
   input logic             fall_stb,
   input logic             cfg_err,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] n_cur
);

   assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= n_cur);

   assert_rise_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |-> sclk_o);

   assert_bypass_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |-> (!rise_stb && !fall_stb && !cfg_err));

   assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (!rise_stb && !fall_stb && !sclk_o));

   assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !bypass) |=> (bypass || (!sclk_o && cnt_q == '0)));

   assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rise_stb, fall_stb}));

   assert_fall_after_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_stb && $past(!bypass)) |-> (!sclk_o && $past(sclk_o)));

endmodule

bind sclk_duty_gen sdg_checker #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en       (en),
   .bypass   (bypass),
   .sclk_o   (sclk_o),
   .rise_stb (rise_stb),
   .fall_stb (fall_stb),
   .cfg_err  (cfg_err),
   .cnt_q    (cnt_q),
   .n_cur    (n_cur)
);

// File: tb/sim_sclk_duty_gen.sv
`timescale 1ns/1ps
module sim_sclk_duty_gen;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         en = 1'b0;
   logic         bypass = 1'b0;
   logic [W-1:0] per_cnt = '0;
   logic [W-1:0] thr_a = '0;
   logic [W-1:0] thr_b = '0;
   logic         sclk_o, rise_stb, fall_stb, cfg_err;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   sclk_duty_gen #(.CNT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .bypass(bypass),
      .per_cnt(per_cnt), .thr_a(thr_a), .thr_b(thr_b),
      .sclk_o(sclk_o), .rise_stb(rise_stb), .fall_stb(fall_stb),
      .cfg_err(cfg_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drive(input int n, input int a, input int b);
      per_cnt = W'(n);
      thr_a   = W'(a);
      thr_b   = W'(b);
   endtask

   // Waits for the next rise strobe, optionally changes counts right there,
   // then measures the high run and the low run of that period.
   task automatic measure(input bit chg, input int n2, input int a2, input int b2,
                          output int hi, output int lo, output bit rise_ok,
                          output bit fall_ok, output bit found);
      hi = 0; lo = 0; rise_ok = 0; fall_ok = 0; found = 0;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (rise_stb) begin found = 1; break; end
      end
      if (!found) return;
      rise_ok = sclk_o;
      if (chg) drive(n2, a2, b2);
      while (sclk_o && hi < 2000) begin hi++; @(negedge clk); end
      fall_ok = fall_stb;
      while (!rise_stb && lo < 2000) begin
         if (sclk_o) fall_ok = 0;
         lo++;
         @(negedge clk);
      end
   endtask

   task automatic t_period(input int n, input int a, input int b);
      int hi, lo, d;
      bit rok, fok, fnd;
      drive(n, a, b);
      measure(0, 0, 0, 0, hi, lo, rok, fok, fnd);
      chk(fnd, "R1 rise strobe seen", int'(fnd), 1);
      chk(hi + lo == n + 1, "R1 period length", hi + lo, n + 1);
      if (a > b) begin
         d = a - b;
         chk(hi == d, "R2 high run", hi, d);
      end else begin
         d = b - a;
         chk(lo == d, "R3 low run", lo, d);
      end
      chk(rok, "R4 period opens high", int'(rok), 1);
      chk(fok, "R10 fall strobe at first low cycle", int'(fok), 1);
   endtask

   task automatic t_reset();
      en = 1'b1;
      drive(9, 9, 3);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk({sclk_o, rise_stb, fall_stb, cfg_err} == 4'b0, "R11 outputs in reset",
             int'({sclk_o, rise_stb, fall_stb, cfg_err}), 0);
      end
      rst_n = 1'b1;
   endtask

   task automatic t_offsets();
      int h1, l1, h2, l2;
      bit r, f, fnd;
      drive(9, 9, 3);
      measure(0, 0, 0, 0, h1, l1, r, f, fnd);
      drive(9, 6, 0);
      measure(0, 0, 0, 0, h2, l2, r, f, fnd);
      chk(h1 == 6 && l1 == 4, "R5 pair (9,3) gives 6/4", h1 * 100 + l1, 604);
      chk(h2 == 6 && l2 == 4, "R5 pair (6,0) gives 6/4", h2 * 100 + l2, 604);
   endtask

   task automatic t_midchange();
      int hi, lo;
      bit r, f, fnd;
      drive(9, 9, 3);
      measure(0, 0, 0, 0, hi, lo, r, f, fnd);
      measure(1, 4, 1, 0, hi, lo, r, f, fnd);
      chk(hi == 6 && lo == 4, "R8 running period kept", hi * 100 + lo, 604);
      measure(0, 0, 0, 0, hi, lo, r, f, fnd);
      chk(hi == 1 && lo == 4, "R8 new counts next period", hi * 100 + lo, 104);
   endtask

   task automatic t_invalid(input int n, input int a, input int b, input string tag);
      int highs, strobes;
      drive(n, a, b);
      repeat (60) @(negedge clk);
      chk(cfg_err == 1'b1, tag, int'(cfg_err), 1);
      highs = 0; strobes = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (sclk_o) highs++;
         if (rise_stb || fall_stb) strobes++;
      end
      chk(highs == 0, "R7 clock parked low", highs, 0);
      chk(strobes == 0, "R7 no strobes", strobes, 0);
      drive(5, 0, 2);
      repeat (30) @(negedge clk);
      chk(cfg_err == 1'b0, "R7 flag clears on legal counts", int'(cfg_err), 0);
   endtask

   task automatic t_bypass();
      int bad;
      bad = 0;
      @(negedge clk);
      bypass = 1'b1;
      drive(3, 7, 7);
      for (int i = 0; i < 12; i++) begin
         @(posedge clk); #1;
         if (sclk_o !== 1'b1) bad++;
         @(negedge clk); #1;
         if (sclk_o !== 1'b0) bad++;
         if (rise_stb || fall_stb || cfg_err) bad++;
      end
      chk(bad == 0, "R6 output follows system clock, strobes and flag quiet", bad, 0);
      @(negedge clk);
      bypass = 1'b0;
      drive(5, 0, 2);
   endtask

   task automatic t_enable();
      int idle_hi, hi;
      @(negedge clk);
      en = 1'b0;
      drive(7, 5, 2);
      idle_hi = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (sclk_o || rise_stb || fall_stb) idle_hi++;
      end
      chk(idle_hi == 0, "R9 idle low while disabled", idle_hi, 0);
      en = 1'b1;
      @(negedge clk);
      chk(sclk_o && rise_stb, "R9 first cycle high with rise strobe",
          int'({sclk_o, rise_stb}), 3);
      hi = 0;
      while (sclk_o && hi < 100) begin hi++; @(negedge clk); end
      chk(hi == 3, "R9 first period full high run", hi, 3);
   endtask

   task automatic t_random();
      for (int k = 0; k < 20; k++) begin
         int n, a, b;
         n = 1 + int'($urandom_range(0, 19));
         a = int'($urandom_range(0, n));
         b = int'($urandom_range(0, n));
         while (b == a) b = int'($urandom_range(0, n));
         t_period(n, a, b);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(7));
      t_reset();
      t_period(9, 9, 3);
      t_period(9, 2, 7);
      t_period(4, 4, 0);
      t_period(4, 0, 4);
      t_period(1, 1, 0);
      t_offsets();
      t_midchange();
      t_invalid(9, 3, 3, "R7 equal thresholds flagged");
      t_invalid(5, 7, 0, "R7 threshold above N flagged");
      t_bypass();
      t_period(5, 0, 2);
      t_enable();
      t_random();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule